// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in in a single combinational pass. Each bit first forms a local generate term (both operand bits set) and a local propagate term (operand bits differ). Four identical 4-ary lookahead units turn those terms into one generate/propagate pair per 4-bit group. A fifth unit of the same form reads the four group pairs and the carry-in, and returns the carry entering each group. The group units then use that carry to form the carry into every bit, and each sum bit is the XOR of its propagate term and its incoming carry.

The block also drives its own block-level generate and propagate. A parent lookahead unit in a wider adder can therefore treat this adder as one group. The carry-out is the block generate ORed with the block propagate ANDed with the carry-in. There is no clock, no state and no handshake. The outputs follow the inputs after the logic settles.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, taken as unsigned numbers.
- R2: `cout_o` equals bit 16 of the 17-bit result of `a_i + b_i + cin_i`.
- R3: `blk_g_o` is 1 exactly when `a_i + b_i` overflows 16 bits with no carry-in.
- R4: `blk_p_o` is 1 exactly when `a_i ^ b_i` is all ones.
- R5: `cout_o` equals `blk_g_o | (blk_p_o & cin_i)` for every input.
- R6: `blk_g_o` and `blk_p_o` are never 1 together.
- R7: `cin_i` has no effect on `blk_g_o` or `blk_p_o`. With the operands held, toggling `cin_i` leaves both outputs unchanged.
- R8: A carry produced in any 4-bit group (bits 4k+3..4k) reaches the next group. `16'hF << 4k` plus `16'h1 << 4k` gives `16'h10 << 4k`, and for k = 3 it gives a sum of zero with `cout_o` = 1.
- R9: A carry-in reaches the carry-out through all 16 bits when every bit propagates. If `a_i ^ b_i` is all ones and `cin_i` = 1, the sum is zero and `cout_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| blk_g_o | output | 1 | Block generate, for a parent lookahead unit |
| blk_p_o | output | 1 | Block propagate, for a parent lookahead unit |

## Verification
The bench builds the adder with its default shape: four groups of four bits, so the second-level unit has the same arity as the group units. This shape puts every group boundary inside the 16-bit range, so a carry can be started in each group and seen arriving in the next. It also makes the all-propagate ripple from carry-in to carry-out short enough to drive directly. A pseudo-random operand sweep compares sum, carry-out and block generate/propagate with plain integer addition.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_GRP_W = 4;
  localparam int unsigned CLA_N_GRP = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } gp_pair_t;
endpackage

// File: rtl/cla_bit_terms.sv
module cla_bit_terms #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    cla_pkg::gp_pair_t pair;
    assign pair.gen  = a_i[i] & b_i[i];
    assign pair.prop = a_i[i] ^ b_i[i];
    assign gen_o[i]  = pair.gen;
    assign prop_o[i] = pair.prop;
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned ARITY = 4
) (
  input  logic [ARITY-1:0] gen_i,
  input  logic [ARITY-1:0] prop_i,
  input  logic             cin_i,
  output logic [ARITY-1:0] carry_o,
  output logic             grp_gen_o,
  output logic             grp_prop_o
);
  logic [ARITY-1:0] carry_q;
  logic             ggen;
  logic             gprop;

  always_comb begin
    for (int k = 0; k < ARITY; k++) begin
      logic cv;
      logic term;
      cv = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = gen_i[j];
        for (int m = j + 1; m < k; m++) term = term & prop_i[m];
        cv = cv | term;
      end
      term = cin_i;
      for (int m = 0; m < k; m++) term = term & prop_i[m];
      carry_q[k] = cv | term;
    end
  end

  always_comb begin
    ggen  = 1'b0;
    gprop = 1'b1;
    for (int j = 0; j < ARITY; j++) begin
      logic term;
      term = gen_i[j];
      for (int m = j + 1; m < ARITY; m++) term = term & prop_i[m];
      ggen  = ggen | term;
      gprop = gprop & prop_i[j];
    end
  end

  assign carry_o    = carry_q;
  assign grp_gen_o  = ggen;
  assign grp_prop_o = gprop;
endmodule

// File: rtl/cla_sum_xor.sv
module cla_sum_xor #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum_o[i] = prop_i[i] ^ carry_i[i];
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int unsigned GRP_W = cla_pkg::CLA_GRP_W,
  parameter int unsigned N_GRP = cla_pkg::CLA_N_GRP,
  localparam int unsigned WIDTH = GRP_W * N_GRP
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             blk_g_o,
  output logic             blk_p_o
);
  logic [WIDTH-1:0] bit_gen;
  logic [WIDTH-1:0] bit_prop;
  logic [WIDTH-1:0] bit_carry;
  logic [N_GRP-1:0] grp_gen;
  logic [N_GRP-1:0] grp_prop;
  logic [N_GRP-1:0] grp_cin;
  logic             top_gen;
  logic             top_prop;

  cla_bit_terms #(.WIDTH(WIDTH)) terms_i (
    .a_i   (a_i),
    .b_i   (b_i),
    .gen_o (bit_gen),
    .prop_o(bit_prop)
  );

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    logic [GRP_W-1:0] c_loc;
    logic             gg;
    logic             gpp;
    cla_lookahead #(.ARITY(GRP_W)) la_i (
      .gen_i     (bit_gen[k*GRP_W +: GRP_W]),
      .prop_i    (bit_prop[k*GRP_W +: GRP_W]),
      .cin_i     (grp_cin[k]),
      .carry_o   (c_loc),
      .grp_gen_o (gg),
      .grp_prop_o(gpp)
    );
    assign bit_carry[k*GRP_W +: GRP_W] = c_loc;
    assign grp_gen[k]  = gg;
    assign grp_prop[k] = gpp;
  end

  cla_lookahead #(.ARITY(N_GRP)) top_la_i (
    .gen_i     (grp_gen),
    .prop_i    (grp_prop),
    .cin_i     (cin_i),
    .carry_o   (grp_cin),
    .grp_gen_o (top_gen),
    .grp_prop_o(top_prop)
  );

  cla_sum_xor #(.WIDTH(WIDTH)) sum_i (
    .prop_i (bit_prop),
    .carry_i(bit_carry),
    .sum_o  (sum_o)
  );

  assign cout_o  = top_gen | (top_prop & cin_i);
  assign blk_g_o = top_gen;
  assign blk_p_o = top_prop;
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             blk_g_o,
  input logic             blk_p_o
);
  logic [WIDTH:0] full_ref;
  logic [WIDTH:0] nocin_ref;
  logic           known;

  always_comb begin
    full_ref  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
    nocin_ref = {1'b0, a_i} + {1'b0, b_i};
    known     = !$isunknown({a_i, b_i, cin_i, sum_o, cout_o, blk_g_o, blk_p_o});
    if (known) begin
      assert_sum_R1: assert (sum_o == full_ref[WIDTH-1:0]);
      assert_cout_R2: assert (cout_o == full_ref[WIDTH]);
      assert_blk_gen_R3: assert (blk_g_o == nocin_ref[WIDTH]);
      assert_blk_prop_R4: assert (blk_p_o == (&(a_i ^ b_i)));
      assert_cout_form_R5: assert (cout_o == (blk_g_o | (blk_p_o & cin_i)));
      assert_gp_excl_R6: assert (!(blk_g_o && blk_p_o));
    end
  end
endmodule

bind cla16_adder cla16_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .blk_g_o(blk_g_o),
  .blk_p_o(blk_p_o)
);

// File: tb/cla16_adder_tb.sv
module cla16_adder_tb_top;
  localparam int unsigned NV = 12;
  // {a, b, cin, sum, cout, blk_g, blk_p}
  localparam logic [51:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'hFFFF, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1},
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0, 1'b0, 1'b0},
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
    {16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0, 1'b0, 1'b0},
    {16'h0FFF, 16'h0001, 1'b1, 16'h1001, 1'b0, 1'b0, 1'b0},
    {16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, 1'b1, 1'b0},
    {16'h0F0F, 16'h00F1, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;
  logic        bg;
  logic        bp;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;
  int          cycles = 0;

  always #10 clk = ~clk;

  cla16_adder dut_i (
    .a_i    (a),
    .b_i    (b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout),
    .blk_g_o(bg),
    .blk_p_o(bp)
  );

  task automatic check1(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] av, input logic [15:0] bv, input logic cv);
    @(posedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  task automatic check_all(input logic [15:0] es, input logic ec, input logic eg, input logic ep);
    check1("R1 sum", {1'b0, sum}, {1'b0, es});
    check1("R2 cout", {16'h0, cout}, {16'h0, ec});
    check1("R3 blk_g", {16'h0, bg}, {16'h0, eg});
    check1("R4 blk_p", {16'h0, bp}, {16'h0, ep});
    check1("R5 cout form", {16'h0, cout}, {16'h0, bg | (bp & cin)});
    check1("R6 g/p exclusive", {16'h0, bg & bp}, 17'h0);
  endtask

  task automatic run_model(input logic [15:0] av, input logic [15:0] bv, input logic cv);
    logic [16:0] full;
    logic [16:0] nc;
    full = {1'b0, av} + {1'b0, bv} + {16'h0, cv};
    nc   = {1'b0, av} + {1'b0, bv};
    drive(av, bv, cv);
    check_all(full[15:0], full[16], nc[16], &(av ^ bv));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic        g0;
    logic        p0;
    // reset state: operands held at zero while reset is low
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all(16'h0000, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    // table of vectors (R1 R2 R3 R4; rows 3 and 9 also cover R9)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][51:36], VEC[i][35:20], VEC[i][19]);
      check_all(VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R8: carry crossing each group boundary
    for (int k = 0; k < 4; k++) begin
      drive(16'hF << (4 * k), 16'h1 << (4 * k), 1'b0);
      check_all(16'h10 << (4 * k), (k == 3), (k == 3), 1'b0);
    end

    // R9: full propagate ripple from carry-in
    drive(16'h3C5A, 16'hC3A5, 1'b1);
    check_all(16'h0000, 1'b1, 1'b0, 1'b1);

    // R7: cin toggle leaves block g/p unchanged
    lf = 16'hACE1;
    for (int i = 0; i < 8; i++) begin
      drive(lf, ~lf ^ (16'h1 << i), 1'b0);
      g0 = bg; p0 = bp;
      drive(lf, ~lf ^ (16'h1 << i), 1'b1);
      check1("R7 blk_g vs cin", {16'h0, bg}, {16'h0, g0});
      check1("R7 blk_p vs cin", {16'h0, bp}, {16'h0, p0});
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end

    // pseudo-random sweep against integer addition
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] bv;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      bv = {lf[7:0], lf[15:8]} ^ 16'h5A3C;
      run_model(lf, (i % 5 == 0) ? ~lf : bv, lf[3]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule